// File: doc/BRIEF.md
# Special-Purpose 16-Register File

This block is the architectural register store of a small 16-bit processor. It keeps sixteen 16-bit registers, of which index 0 is the program counter, index 1 the stack pointer, index 2 the status word and index 3 a hardwired zero source. Indices 4 to 15 are general purpose. The block offers two combinational read ports, one write port that accepts either a full word or a byte, and a separate post-increment port. The operand fetch logic uses that port when it walks a pointer with indirect addressing and auto-increment.

The execute stage drives the write port with results. It drives the increment port with the pointer register of an auto-increment operand and the operand size. The block works out the step from the register index: the program counter and stack pointer always move by two, and the other pointers move by the operand size. The status word is only stored here. Its flag values come from the ALU through the ordinary write port. The block decodes its fields onto dedicated outputs for the control logic.

Top module: `sp_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to zero. The program counter is then loaded from `pc_reset_val`, with bit 0 forced to zero.
- R2: Both read ports are combinational and return the register selected by their index. A write or increment takes effect at the rising clock edge, so a read in the same cycle returns the old value.
- R3: Register 3 reads as zero on both read ports. Any write or increment aimed at it is discarded.
- R4: A word write (`wr_byte` = 0) stores all 16 bits of `wr_data`.
- R5: A byte write (`wr_byte` = 1) stores `wr_data[7:0]` and sets bits 15:8 of the target register to zero.
- R6: Bit 0 of the program counter is always zero, whatever value is written to it.
- R7: An increment of register 0 or register 1 adds 2, whatever the value of `inc_byte`.
- R8: An increment of registers 4 to 15 adds 1 when `inc_byte` = 1 and 2 when `inc_byte` = 0. The sum wraps modulo 2^16.
- R9: An increment aimed at register 2 (status) has no effect.
- R10: When the write port and the increment port target the same register in one cycle, the written value is stored. When they target different registers, both updates happen.
- R11: The status outputs follow the stored register 2: `sr_flags` = {bit 8, bit 2, bit 1, bit 0} (overflow, negative, zero, carry), `sr_gie` = bit 3, `sr_lpm` = bits 7:4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pc_reset_val | input | 16 | Program counter value loaded during reset |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write target register |
| wr_byte | input | 1 | 1 = byte write, 0 = word write |
| wr_data | input | 16 | Write data |
| inc_en | input | 1 | Post-increment enable |
| inc_idx | input | 4 | Register to increment |
| inc_byte | input | 1 | 1 = byte operand, 0 = word operand |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 16 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 16 | Read port B data |
| pc_q | output | 16 | Current program counter |
| sp_q | output | 16 | Current stack pointer |
| sr_q | output | 16 | Current status word |
| sr_flags | output | 4 | Overflow, negative, zero, carry |
| sr_gie | output | 1 | Global interrupt enable bit |
| sr_lpm | output | 4 | Low-power control bits |

## Verification
The bench targets the following corner cases and the fault each one exposes:
- An odd value written to the program counter exposes a design that lets the PC go misaligned.
- A byte write of a value with a non-zero upper byte exposes a design that merges bytes or keeps stale upper bits.
- Byte-sized increments of the PC and SP expose a step of 1 where the step must be 2.
- A byte increment of 0xFFFF exposes a missing wrap to zero.
- Writes and increments aimed at registers 2 and 3 expose a sink that is not really zero, or a status word that moves on its own.
- A simultaneous write and increment to one register shows whether the wrong port wins.
- A read in the same cycle as a write catches a port that bypasses the new value early.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int DATA_W   = 16;
    localparam int NUM_REGS = 16;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int BYTE_W   = 8;

    localparam int PC_IDX = 0;
    localparam int SP_IDX = 1;
    localparam int SR_IDX = 2;
    localparam int CG_IDX = 3;

    // status word field positions
    localparam int SR_C_BIT   = 0;
    localparam int SR_Z_BIT   = 1;
    localparam int SR_N_BIT   = 2;
    localparam int SR_GIE_BIT = 3;
    localparam int SR_LPM_LO  = 4;
    localparam int SR_LPM_W   = 4;
    localparam int SR_V_BIT   = 8;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic {
        SZ_WORD = 1'b0,
        SZ_BYTE = 1'b1
    } size_e;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        size_e size;
        word_t data;
    } wr_req_t;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        size_e size;
    } inc_req_t;

    // byte results are zero-extended into the register
    function automatic word_t size_fit(word_t d, size_e s);
        if (s == SZ_BYTE)
            return {{(DATA_W-BYTE_W){1'b0}}, d[BYTE_W-1:0]};
        return d;
    endfunction

    // pointer step: fixed 2 for PC/SP, none for SR/CG, operand size otherwise
    function automatic word_t inc_step(idx_t i, size_e s);
        if (i == idx_t'(PC_IDX) || i == idx_t'(SP_IDX))
            return word_t'(2);
        if (i == idx_t'(SR_IDX) || i == idx_t'(CG_IDX))
            return '0;
        return (s == SZ_BYTE) ? word_t'(1) : word_t'(2);
    endfunction
endpackage

// File: rtl/rf_reg_slot.sv
module rf_reg_slot
    import rf_pkg::*;
#(
    parameter bit ALIGN = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  word_t rst_val,
    input  logic  wr_hit,
    input  word_t wr_val,
    input  logic  inc_hit,
    input  word_t step,
    output word_t q
);
    localparam word_t KEEP = ALIGN ? ~word_t'(1) : '1;

    word_t nxt;

    always_comb begin
        if (wr_hit)
            nxt = wr_val;
        else if (inc_hit)
            nxt = q + step;
        else
            nxt = q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= rst_val & KEEP;
        else
            q <= nxt & KEEP;
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
(
    input  word_t [NUM_REGS-1:0] regs,
    input  idx_t                 idx,
    output word_t                data
);
    always_comb begin
        if (idx == idx_t'(CG_IDX))
            data = '0;
        else
            data = regs[idx];
    end
endmodule

// File: rtl/sp_regfile.sv
module sp_regfile
    import rf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DATA_W-1:0]    pc_reset_val,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_byte,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 inc_en,
    input  logic [IDX_W-1:0]     inc_idx,
    input  logic                 inc_byte,
    input  logic [IDX_W-1:0]     rd_a_idx,
    output logic [DATA_W-1:0]    rd_a_data,
    input  logic [IDX_W-1:0]     rd_b_idx,
    output logic [DATA_W-1:0]    rd_b_data,
    output logic [DATA_W-1:0]    pc_q,
    output logic [DATA_W-1:0]    sp_q,
    output logic [DATA_W-1:0]    sr_q,
    output logic [3:0]           sr_flags,
    output logic                 sr_gie,
    output logic [SR_LPM_W-1:0]  sr_lpm
);
    wr_req_t wr;
    inc_req_t inc;
    word_t wr_val;
    word_t step;
    word_t [NUM_REGS-1:0] regs;

    assign wr  = '{en: wr_en, idx: wr_idx, size: size_e'(wr_byte), data: wr_data};
    assign inc = '{en: inc_en, idx: inc_idx, size: size_e'(inc_byte)};

    assign wr_val = size_fit(wr.data, wr.size);
    assign step   = inc_step(inc.idx, inc.size);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        if (i == CG_IDX) begin : g_sink
            assign regs[i] = '0;
        end else begin : g_reg
            logic wr_hit;
            logic inc_hit;
            assign wr_hit  = wr.en && (wr.idx == idx_t'(i));
            assign inc_hit = inc.en && (inc.idx == idx_t'(i)) && (step != '0);
            rf_reg_slot #(.ALIGN(i == PC_IDX)) u_slot (
                .clk     (clk),
                .rst     (rst),
                .rst_val ((i == PC_IDX) ? pc_reset_val : '0),
                .wr_hit  (wr_hit),
                .wr_val  (wr_val),
                .inc_hit (inc_hit),
                .step    (step),
                .q       (regs[i])
            );
        end
    end

    rf_read_port u_rd_a (.regs(regs), .idx(rd_a_idx), .data(rd_a_data));
    rf_read_port u_rd_b (.regs(regs), .idx(rd_b_idx), .data(rd_b_data));

    assign pc_q     = regs[PC_IDX];
    assign sp_q     = regs[SP_IDX];
    assign sr_q     = regs[SR_IDX];
    assign sr_flags = {regs[SR_IDX][SR_V_BIT], regs[SR_IDX][SR_N_BIT],
                       regs[SR_IDX][SR_Z_BIT], regs[SR_IDX][SR_C_BIT]};
    assign sr_gie   = regs[SR_IDX][SR_GIE_BIT];
    assign sr_lpm   = regs[SR_IDX][SR_LPM_LO +: SR_LPM_W];

    // ---------------- assertions ----------------
    assert_sink_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == idx_t'(CG_IDX)) |-> (rd_a_data == '0 && regs[CG_IDX] == '0));

    assert_byte_upper_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_byte && wr_idx != idx_t'(CG_IDX))
        |=> (regs[$past(wr_idx)][DATA_W-1:BYTE_W] == '0));

    assert_pc_even_R6: assert property (@(posedge clk) disable iff (rst)
        pc_q[0] == 1'b0);

    assert_pc_step_R7: assert property (@(posedge clk) disable iff (rst)
        (inc_en && inc_idx == idx_t'(PC_IDX) && !(wr_en && wr_idx == idx_t'(PC_IDX)))
        |=> (pc_q == $past(pc_q) + word_t'(2)));

    assert_sr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (inc_en && inc_idx == idx_t'(SR_IDX) && !(wr_en && wr_idx == idx_t'(SR_IDX)))
        |=> $stable(sr_q));

    assert_wr_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && inc_en && wr_idx == inc_idx && !wr_byte
         && wr_idx != idx_t'(CG_IDX) && wr_idx != idx_t'(PC_IDX))
        |=> (regs[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: tb/test_sp_regfile.sv
`timescale 1ns/1ps
module test_sp_regfile;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] pc_reset_val;
    logic        wr_en, wr_byte, inc_en, inc_byte;
    logic [3:0]  wr_idx, inc_idx, rd_a_idx, rd_b_idx;
    logic [15:0] wr_data;
    logic [15:0] rd_a_data, rd_b_data, pc_q, sp_q, sr_q;
    logic [3:0]  sr_flags, sr_lpm;
    logic        sr_gie;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    logic [15:0] exp_r [16];

    always #4 clk = ~clk;

    sp_regfile i_sp_regfile (
        .clk(clk), .rst(rst), .pc_reset_val(pc_reset_val),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte), .wr_data(wr_data),
        .inc_en(inc_en), .inc_idx(inc_idx), .inc_byte(inc_byte),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .pc_q(pc_q), .sp_q(sp_q), .sr_q(sr_q),
        .sr_flags(sr_flags), .sr_gie(sr_gie), .sr_lpm(sr_lpm)
    );

    function automatic logic [15:0] m_step(logic [3:0] i, logic b);
        if (i == 4'd0 || i == 4'd1) return 16'd2;
        if (i == 4'd2 || i == 4'd3) return 16'd0;
        return b ? 16'd1 : 16'd2;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    // enables are low here, so clock edges during reads change nothing
    task automatic chk_reg(string req, int idx);
        rd_a_idx = 4'(idx);
        rd_b_idx = 4'(15 - idx);
        #1;
        chk(req, rd_a_data, exp_r[idx]);
        chk(req, rd_b_data, exp_r[15 - idx]);
    endtask

    // called just after a falling edge
    task automatic cyc(logic we, logic [3:0] wi, logic wb, logic [15:0] wd,
                       logic ie, logic [3:0] ii, logic ib);
        logic [15:0] nx [16];
        logic [15:0] v;
        nx = exp_r;
        wr_en = we; wr_idx = wi; wr_byte = wb; wr_data = wd;
        inc_en = ie; inc_idx = ii; inc_byte = ib;
        if (ie) nx[ii] = exp_r[ii] + m_step(ii, ib);
        if (we && wi != 4'd3) begin
            v = wb ? {8'h00, wd[7:0]} : wd;
            if (wi == 4'd0) v[0] = 1'b0;
            nx[wi] = v;
        end
        @(posedge clk);
        exp_r = nx;
        #1;
        wr_en = 1'b0; inc_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; pc_reset_val = 16'h1235;
        wr_en = 0; wr_idx = 0; wr_byte = 0; wr_data = 0;
        inc_en = 0; inc_idx = 0; inc_byte = 0; rd_a_idx = 0; rd_b_idx = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        foreach (exp_r[i]) exp_r[i] = 16'h0;
        exp_r[0] = 16'h1234;
        // R1 reset state
        for (int i = 0; i < 16; i++) chk_reg("R1", i);
        @(negedge clk);

        // R4 word write
        cyc(1, 4'd4, 0, 16'hBEEF, 0, 0, 0);
        chk_reg("R4", 4);
        @(negedge clk);
        // R5 byte write clears upper byte, general and SP
        cyc(1, 4'd6, 1, 16'hA5C3, 0, 0, 0);
        chk_reg("R5", 6);
        cyc(1, 4'd1, 1, 16'h7E81, 0, 0, 0);
        chk("R5", sp_q, 16'h0081);
        @(negedge clk);
        // R6 PC alignment
        cyc(1, 4'd0, 0, 16'h4321, 0, 0, 0);
        chk("R6", pc_q, 16'h4320);
        cyc(1, 4'd0, 1, 16'h12FF, 0, 0, 0);
        chk("R6", pc_q, 16'h00FE);
        // R3 sink
        cyc(1, 4'd3, 0, 16'hFFFF, 0, 0, 0);
        chk_reg("R3", 3);
        @(negedge clk);
        cyc(0, 0, 0, 0, 1, 4'd3, 0);
        chk_reg("R3", 3);
        @(negedge clk);
        // R7 PC/SP step 2 even for byte operands
        cyc(0, 0, 0, 0, 1, 4'd0, 1);
        chk("R7", pc_q, 16'h0100);
        cyc(0, 0, 0, 0, 1, 4'd1, 1);
        chk("R7", sp_q, 16'h0083);
        // R8 size-dependent step and wrap
        cyc(1, 4'd7, 0, 16'h00FF, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 4'd7, 1);
        chk_reg("R8", 7);
        @(negedge clk);
        chk("R8", exp_r[7], 16'h0100);
        cyc(0, 0, 0, 0, 1, 4'd8, 0);
        chk_reg("R8", 8);
        @(negedge clk);
        cyc(1, 4'd9, 0, 16'hFFFF, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 4'd9, 1);
        rd_a_idx = 4'd9; #1;
        chk("R8", rd_a_data, 16'h0000);
        @(negedge clk);
        // R11 status field decode
        cyc(1, 4'd2, 0, 16'h0155, 0, 0, 0);
        chk("R11", {12'h0, sr_flags}, 16'h000D);
        chk("R11", {15'h0, sr_gie}, 16'h0000);
        chk("R11", {12'h0, sr_lpm}, 16'h0005);
        cyc(1, 4'd2, 0, 16'h0008, 0, 0, 0);
        chk("R11", {15'h0, sr_gie}, 16'h0001);
        // R9 increment of status does nothing
        cyc(0, 0, 0, 0, 1, 4'd2, 0);
        chk("R9", sr_q, 16'h0008);
        // R10 write wins on same register; different registers both update
        cyc(1, 4'd10, 0, 16'h1111, 1, 4'd10, 0);
        chk_reg("R10", 10);
        @(negedge clk);
        cyc(1, 4'd11, 0, 16'h2222, 1, 4'd12, 1);
        chk_reg("R10", 11);
        chk_reg("R10", 12);
        @(negedge clk);
        // R2 same-cycle read returns old value
        wr_en = 1; wr_idx = 4'd5; wr_byte = 0; wr_data = 16'hCAFE;
        rd_a_idx = 4'd5; #1;
        chk("R2", rd_a_data, exp_r[5]);
        @(posedge clk); #1;
        wr_en = 0; exp_r[5] = 16'hCAFE;
        chk("R2", rd_a_data, 16'hCAFE);
        @(negedge clk);

        // R2 random mix of writes and increments
        for (int k = 0; k < 800; k++) begin
            logic [31:0] r;
            r = $urandom();
            cyc(r[0], r[7:4], r[1], 16'($urandom()), r[2], r[11:8], r[3]);
            chk_reg("R2", int'(r[15:12]));
            chk("R2", pc_q, exp_r[0]);
            chk("R2", sp_q, exp_r[1]);
            @(negedge clk);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule